// File: doc/BRIEF.md
# Carry-Save Fused Multiply-Add / Subtract Unit

This block is a datapath cell for signal-processing kernels in which results feed straight into later arithmetic. Every operand except the coefficient arrives in redundant carry-save form: a pair of N-bit vectors, a carry part and a sum part, whose value is the sum of the two. The result leaves in the same form. A chain of such cells therefore never waits on a carry-propagate adder between a multiply and the add that follows it.

A 2-bit operation code selects the fused function. The options are a binary coefficient times X plus Y plus K, the coefficient times K plus X plus Y, the difference X minus Y, or X passed through unchanged. Two routing multiplexers choose which operand feeds the multiplier and which operands feed the adder inputs. Partial products of the coefficient with both vectors of the multiplicand are reduced together with the addends in a single 3:2 compressor tree. Subtraction inverts both vectors of the subtrahend and injects +2 through the tree's carry-in slot.

The carry/sum pair is registered, so the result appears one cycle after the request and is marked with a valid flag. An optional carry-propagate adder, enabled by a parameter, turns the registered pair into a binary value for the last cell of a chain. All internal vectors are 2N+2 bits wide, and all results wrap modulo 2^(2N+2).

Top module: `csfu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `w_c` and `w_s` become 0 at that edge.
- R2: `out_valid` at each clock edge equals `in_valid` sampled at the previous edge (one cycle of latency).
- R3: With `op` = 2'b00 and `in_valid` high, the next result satisfies w_c + w_s ≡ A·(x_c+x_s) + (y_c+y_s) + (k_c+k_s) mod 2^(2N+2).
- R4: With `op` = 2'b01 and `in_valid` high, the next result satisfies w_c + w_s ≡ A·(k_c+k_s) + (x_c+x_s) + (y_c+y_s) mod 2^(2N+2).
- R5: With `op` = 2'b10 and `in_valid` high, the next result satisfies w_c + w_s ≡ (x_c+x_s) − (y_c+y_s) mod 2^(2N+2), including the case where Y exceeds X. A and K are ignored.
- R6: With `op` = 2'b11 and `in_valid` high, the next result satisfies w_c + w_s ≡ x_c + x_s. A, Y and K have no effect.
- R7: With `in_valid` low, `w_c`, `w_s` and `w_bin` hold their previous values whatever the other inputs do.
- R8: With `HAS_CPA` = 1 (the default), `w_bin` equals (w_c + w_s) mod 2^(2N+2) in the same cycle as the pair it converts.
- R9: Maximum-magnitude operands (all-ones coefficient and vectors) wrap modulo 2^(2N+2) and do not lose bits below that width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands and op are captured when high |
| op | input | 2 | Operation: 00 A·X+Y+K, 01 A·K+X+Y, 10 X−Y, 11 pass X |
| coef_a | input | N | Binary unsigned coefficient |
| x_c | input | N | Carry vector of operand X |
| x_s | input | N | Sum vector of operand X |
| y_c | input | N | Carry vector of operand Y |
| y_s | input | N | Sum vector of operand Y |
| k_c | input | N | Carry vector of operand K |
| k_s | input | N | Sum vector of operand K |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| w_c | output | 2N+2 | Carry vector of the result |
| w_s | output | 2N+2 | Sum vector of the result |
| w_bin | output | 2N+2 | Binary result (w_c + w_s), zero when `HAS_CPA` = 0 |

## Verification
Random carry-save operands are applied under every operation code. The carry and sum vectors of each operand are chosen independently, so a routing fault that swaps the carry part of one operand with that of another changes the summed result. Directed vectors separate the two multiply-add forms by using distinct X and K with a non-unit coefficient. A zero coefficient exposes a multiplier that leaks into the adder path. Y greater than X checks the wrap of the +2 subtraction correction, and all-ones inputs check that no bit below the 2N+2 width is dropped. Pass-through and subtraction are driven with junk on the unused inputs, and idle cycles carry junk operands to show that the registered result holds.

// File: rtl/csfu_pkg.sv
package csfu_pkg;

    typedef enum logic [1:0] {
        OP_MAC_X  = 2'b00,
        OP_MAC_K  = 2'b01,
        OP_SUB_XY = 2'b10,
        OP_PASS_X = 2'b11
    } csfu_op_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'b00,
        SRC_Y    = 2'b01,
        SRC_K    = 2'b10
    } add_src_e;

    typedef struct packed {
        logic     mul_en;
        logic     mcand_k;
        logic     first_x;
        add_src_e second;
        logic     negate;
    } route_ctl_t;

    localparam int unsigned SUB_CORRECTION = 2;

    function automatic route_ctl_t decode_op(input csfu_op_e op);
        route_ctl_t r;
        r = '{mul_en: 1'b0, mcand_k: 1'b0, first_x: 1'b1, second: SRC_ZERO, negate: 1'b0};
        unique case (op)
            OP_MAC_X: begin
                r.mul_en  = 1'b1;
                r.first_x = 1'b0;
                r.second  = SRC_K;
            end
            OP_MAC_K: begin
                r.mul_en  = 1'b1;
                r.mcand_k = 1'b1;
                r.second  = SRC_Y;
            end
            OP_SUB_XY: begin
                r.second = SRC_Y;
                r.negate = 1'b1;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/csfu_route.sv
module csfu_route
    import csfu_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned WD = 2 * N + 2
) (
    input  route_ctl_t      ctl,
    input  logic [N-1:0]    coef_a,
    input  logic [N-1:0]    x_c,
    input  logic [N-1:0]    x_s,
    input  logic [N-1:0]    y_c,
    input  logic [N-1:0]    y_s,
    input  logic [N-1:0]    k_c,
    input  logic [N-1:0]    k_s,
    output logic [N-1:0]    a_eff,
    output logic [N-1:0]    mc_c,
    output logic [N-1:0]    mc_s,
    output logic [WD-1:0]   add1_c,
    output logic [WD-1:0]   add1_s,
    output logic [WD-1:0]   add2_c,
    output logic [WD-1:0]   add2_s,
    output logic [WD-1:0]   cin
);
    logic [N-1:0] sec_c;
    logic [N-1:0] sec_s;

    // multiplicand multiplexer
    always_comb begin
        a_eff = ctl.mul_en ? coef_a : '0;
        mc_c  = ctl.mcand_k ? k_c : x_c;
        mc_s  = ctl.mcand_k ? k_s : x_s;
    end

    // addend multiplexer
    always_comb begin
        add1_c = ctl.first_x ? WD'(x_c) : WD'(y_c);
        add1_s = ctl.first_x ? WD'(x_s) : WD'(y_s);
        unique case (ctl.second)
            SRC_Y:   begin sec_c = y_c; sec_s = y_s; end
            SRC_K:   begin sec_c = k_c; sec_s = k_s; end
            default: begin sec_c = '0;  sec_s = '0;  end
        endcase
        // two's complement of a carry-save value: invert both vectors, add 2
        add2_c = ctl.negate ? ~WD'(sec_c) : WD'(sec_c);
        add2_s = ctl.negate ? ~WD'(sec_s) : WD'(sec_s);
        cin    = ctl.negate ? WD'(SUB_CORRECTION) : '0;
    end
endmodule

// File: rtl/csfu_ppgen.sv
module csfu_ppgen #(
    parameter int unsigned N  = 8,
    parameter int unsigned WD = 2 * N + 2
) (
    input  logic [N-1:0]             a,
    input  logic [N-1:0]             mc_c,
    input  logic [N-1:0]             mc_s,
    output logic [2*N-1:0][WD-1:0]   pp
);
    // one row per coefficient bit for each vector of the multiplicand
    for (genvar i = 0; i < N; i++) begin : g_row
        assign pp[2*i]     = a[i] ? (WD'(mc_c) << i) : '0;
        assign pp[2*i + 1] = a[i] ? (WD'(mc_s) << i) : '0;
    end
endmodule

// File: rtl/csfu_tree.sv
module csfu_tree #(
    parameter int unsigned WD   = 18,
    parameter int unsigned ROWS = 20
) (
    input  logic [ROWS-1:0][WD-1:0] rows,
    input  logic [WD-1:0]           cin,
    output logic [WD-1:0]           sum_o,
    output logic [WD-1:0]           carry_o
);
    logic [ROWS:0][WD-1:0] s_ch;
    logic [ROWS:0][WD-1:0] c_ch;

    // the carry-in slot carries the subtraction correction
    assign s_ch[0] = '0;
    assign c_ch[0] = cin;

    for (genvar r = 0; r < ROWS; r++) begin : g_csa
        logic [WD-1:0] maj;
        assign s_ch[r+1] = s_ch[r] ^ c_ch[r] ^ rows[r];
        assign maj       = (s_ch[r] & c_ch[r]) | (s_ch[r] & rows[r]) | (c_ch[r] & rows[r]);
        assign c_ch[r+1] = {maj[WD-2:0], 1'b0};
    end

    assign sum_o   = s_ch[ROWS];
    assign carry_o = c_ch[ROWS];
endmodule

// File: rtl/csfu_cpa.sv
module csfu_cpa #(
    parameter int unsigned WD     = 18,
    parameter bit          ENABLE = 1'b1
) (
    input  logic [WD-1:0] c_in,
    input  logic [WD-1:0] s_in,
    output logic [WD-1:0] bin_o
);
    if (ENABLE) begin : g_cpa
        assign bin_o = c_in + s_in;
    end else begin : g_none
        assign bin_o = '0;
    end
endmodule

// File: rtl/csfu_top.sv
module csfu_top
    import csfu_pkg::*;
#(
    parameter int unsigned N       = 8,
    parameter bit          HAS_CPA = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           op,
    input  logic [N-1:0]         coef_a,
    input  logic [N-1:0]         x_c,
    input  logic [N-1:0]         x_s,
    input  logic [N-1:0]         y_c,
    input  logic [N-1:0]         y_s,
    input  logic [N-1:0]         k_c,
    input  logic [N-1:0]         k_s,
    output logic                 out_valid,
    output logic [2*N+1:0]       w_c,
    output logic [2*N+1:0]       w_s,
    output logic [2*N+1:0]       w_bin
);
    localparam int unsigned WD   = 2 * N + 2;
    localparam int unsigned PPR  = 2 * N;
    localparam int unsigned ROWS = PPR + 4;

    route_ctl_t               ctl;
    logic [N-1:0]             a_eff, mc_c, mc_s;
    logic [WD-1:0]            add1_c, add1_s, add2_c, add2_s, cin;
    logic [PPR-1:0][WD-1:0]   pp;
    logic [ROWS-1:0][WD-1:0]  rows;
    logic [WD-1:0]            t_sum, t_carry;

    assign ctl = decode_op(csfu_op_e'(op));

    csfu_route #(.N(N), .WD(WD)) u_route (
        .ctl(ctl), .coef_a(coef_a),
        .x_c(x_c), .x_s(x_s), .y_c(y_c), .y_s(y_s), .k_c(k_c), .k_s(k_s),
        .a_eff(a_eff), .mc_c(mc_c), .mc_s(mc_s),
        .add1_c(add1_c), .add1_s(add1_s), .add2_c(add2_c), .add2_s(add2_s),
        .cin(cin)
    );

    csfu_ppgen #(.N(N), .WD(WD)) u_pp (
        .a(a_eff), .mc_c(mc_c), .mc_s(mc_s), .pp(pp)
    );

    assign rows = {add2_s, add2_c, add1_s, add1_c, pp};

    csfu_tree #(.WD(WD), .ROWS(ROWS)) u_tree (
        .rows(rows), .cin(cin), .sum_o(t_sum), .carry_o(t_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            w_c       <= '0;
            w_s       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                w_c <= t_carry;
                w_s <= t_sum;
            end
        end
    end

    csfu_cpa #(.WD(WD), .ENABLE(HAS_CPA)) u_cpa (
        .c_in(w_c), .s_in(w_s), .bin_o(w_bin)
    );

    // ---------------- assertions ----------------
    function automatic logic [WD-1:0] csv(input logic [N-1:0] c, input logic [N-1:0] s);
        return WD'(c) + WD'(s);
    endfunction

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && w_c == '0 && w_s == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(w_c) && $stable(w_s)));

    assert_mac_x_value_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00) |=>
            (w_c + w_s) == WD'($past(WD'(coef_a)) * $past(csv(x_c, x_s))
                               + $past(csv(y_c, y_s)) + $past(csv(k_c, k_s))));

    assert_sub_value_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b10) |=>
            (w_c + w_s) == WD'($past(csv(x_c, x_s)) - $past(csv(y_c, y_s))));

    assert_pass_value_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b11) |=> (w_c + w_s) == $past(csv(x_c, x_s)));

endmodule

// File: tb/tb_csfu_top.sv
module tb_csfu_top;
    localparam int unsigned N        = 8;
    localparam int unsigned WD       = 2 * N + 2;
    localparam time         CLK_PER  = 10ns;
    localparam longint      MASK     = (64'd1 << WD) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    op;
    logic [N-1:0]  coef_a, x_c, x_s, y_c, y_s, k_c, k_s;
    logic          out_valid;
    logic [WD-1:0] w_c, w_s, w_bin;

    int n_checks = 0;
    int n_fail   = 0;

    csfu_top #(.N(N), .HAS_CPA(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .coef_a(coef_a),
        .x_c(x_c), .x_s(x_s), .y_c(y_c), .y_s(y_s), .k_c(k_c), .k_s(k_s),
        .out_valid(out_valid), .w_c(w_c), .w_s(w_s), .w_bin(w_bin)
    );

    always #(CLK_PER / 2) clk = ~clk;

    function automatic longint model(input logic [1:0] o, input longint a,
                                     input longint x, input longint y, input longint k);
        longint r;
        case (o)
            2'b00:   r = a * x + y + k;
            2'b01:   r = a * k + x + y;
            2'b10:   r = x - y;
            default: r = x;
        endcase
        return r & MASK;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, result registered at the next rising edge,
    // sampled at the following falling edge
    task automatic run_op(input string req, input logic [1:0] o, input logic [N-1:0] a,
                          input logic [N-1:0] xc, input logic [N-1:0] xs,
                          input logic [N-1:0] yc, input logic [N-1:0] ys,
                          input logic [N-1:0] kc, input logic [N-1:0] ks);
        longint exp;
        in_valid = 1'b1; op = o; coef_a = a;
        x_c = xc; x_s = xs; y_c = yc; y_s = ys; k_c = kc; k_s = ks;
        exp = model(o, longint'(a), longint'(xc) + longint'(xs),
                    longint'(yc) + longint'(ys), longint'(kc) + longint'(ks));
        @(negedge clk);
        check("R2 out_valid", longint'(out_valid), 1);
        check(req, (longint'(w_c) + longint'(w_s)) & MASK, exp);
        check("R8 w_bin", longint'(w_bin), exp);
    endtask

    task automatic idle_hold();
        longint prev_c, prev_s, prev_b;
        prev_c = longint'(w_c); prev_s = longint'(w_s); prev_b = longint'(w_bin);
        in_valid = 1'b0; op = 2'($urandom); coef_a = N'($urandom);
        x_c = N'($urandom); x_s = N'($urandom); y_c = N'($urandom);
        y_s = N'($urandom); k_c = N'($urandom); k_s = N'($urandom);
        @(negedge clk);
        check("R2 no valid", longint'(out_valid), 0);
        check("R7 w_c hold", longint'(w_c), prev_c);
        check("R7 w_s hold", longint'(w_s), prev_s);
        check("R7 w_bin hold", longint'(w_bin), prev_b);
    endtask

    initial begin : watchdog
        #(CLK_PER * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [N-1:0] ones;
        void'($urandom(32'd20240611));
        ones = '1;
        rst = 1'b1; in_valid = 1'b0; op = 2'b00; coef_a = '0;
        x_c = '0; x_s = '0; y_c = '0; y_s = '0; k_c = '0; k_s = '0;
        repeat (3) @(negedge clk);
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 w_c", longint'(w_c), 0);
        check("R1 w_s", longint'(w_s), 0);
        rst = 1'b0;

        // directed corners
        run_op("R3 mac_x distinct", 2'b00, 8'd3, 8'd5, 8'd7, 8'd1, 8'd2, 8'd40, 8'd50);
        run_op("R4 mac_k distinct", 2'b01, 8'd3, 8'd5, 8'd7, 8'd1, 8'd2, 8'd40, 8'd50);
        run_op("R3 zero coef", 2'b00, 8'd0, 8'd200, 8'd100, 8'd9, 8'd4, 8'd1, 8'd3);
        run_op("R9 all ones mac_x", 2'b00, ones, ones, ones, ones, ones, ones, ones);
        run_op("R9 all ones mac_k", 2'b01, ones, ones, ones, ones, ones, ones, ones);
        run_op("R5 y above x", 2'b10, 8'hAA, 8'd1, 8'd2, 8'd200, 8'd255, 8'h55, 8'h66);
        run_op("R5 equal", 2'b10, 8'd7, 8'd30, 8'd40, 8'd40, 8'd30, 8'd1, 8'd1);
        run_op("R6 pass junk", 2'b11, 8'hFF, 8'd17, 8'd250, 8'hFE, 8'hFD, 8'hFC, 8'hFB);
        idle_hold();
        idle_hold();

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [1:0] o;
            string tag;
            o = 2'($urandom);
            case (o)
                2'b00:   tag = "R3 random";
                2'b01:   tag = "R4 random";
                2'b10:   tag = "R5 random";
                default: tag = "R6 random";
            endcase
            run_op(tag, o, N'($urandom), N'($urandom), N'($urandom), N'($urandom),
                   N'($urandom), N'($urandom), N'($urandom));
            if (($urandom % 8) == 0) idle_hold();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule